// File: doc/BRIEF.md
# Shadowed Compare Event Timer

This block is a free-running counter with a bank of compare channels (sixteen by default). Each channel owns two words. In the default wide mode the pair forms one compare value of twice the word width, the counter is equally wide, and both words can be written. In shadow mode the counter is only one word wide. The low word of each channel becomes the live compare value, which software can read but not write. The high word becomes a staging copy that software loads freely.

Each staged value moves into its live word whenever the counter returns to zero. That happens when the counter wraps at its all-ones value, or when channel 0 matches with its counter-reset option set. Starting the counter in shadow mode also moves the staged values into the live words. Software can therefore prepare a complete new compare set while a period is running, and the whole set takes effect together at the next period boundary. When channel 0 resets the counter, the value it transferred most recently sets the length of each period.

The block is driven by a single-cycle write strobe with an address and write data. The read data follows the address combinationally. Each enabled channel raises a one-cycle pulse on its event output when the counter equals its compare value.

Top module: `shadow_cmp_timer`

## Requirements
- R1: After reset, every register word reads 0. The counter is stopped at 0, wide mode is selected, and no event is raised.
- R2: Bit 0 of the control word at address 0 starts the counter. While it is set the counter adds 1 on every clock. While it is clear the counter holds its value.
- R3: The configuration word at address 1 has this layout. Bit 0 lets a channel-0 match reset the counter. Bits NCH..1 enable the events of channels 0..NCH-1, with bit 1 for channel 0. Bit NCH+1 selects shadow mode. The word reads back as written.
- R4: In wide mode, channel c compares the whole counter with {high word, low word}. Both words are writable. Only channels whose enable bit is set raise an event, and no event is raised while the counter is stopped.
- R5: With bit 0 of the configuration word set and the counter running, a match on channel 0 makes the counter's next value 0. The counter therefore steps ..., C0, 0, 1, ...
- R6: In shadow mode the counter is DW bits wide. Its upper word reads 0, and it steps from all-ones to 0.
- R7: In shadow mode, a write to a channel's low word is ignored.
- R8: In shadow mode, writing a high word leaves the live low word unchanged. All high words are copied into their low words when the counter wraps, when channel 0 resets it, and when counting starts. A write made at least 4 counts before such a boundary takes effect at that boundary.
- R9: The shadow-mode bit changes only while the counter is stopped, and any change clears the counter to 0. A write made while the counter is running leaves the mode bit unchanged but still updates the other configuration fields.
- R10: The address map is fixed. Address 2 reads the counter's low word and address 3 its high word, and both are read-only. Channel c's low word is at 2·NCH+2c and its high word at 2·NCH+2c+1. All other addresses read 0.
- R11: An event pulse lasts one cycle. It appears in the cycle after the counter held the matching value, so it coincides with the counter reading one past the match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we | input | 1 | Write strobe, one cycle per write |
| addr | input | AW = log2(4·NCH) | Register address |
| wdata | input | BW = max(DW, NCH+2) | Write data |
| rdata | output | BW | Read data for `addr`, combinational |
| evt | output | NCH | One-cycle event pulse per channel |

## Verification
The bench uses a narrow word (DW = 8), so wraps and channel-0 periods occur within a few hundred cycles. It checks the wrap point directly: a counter that carried into its upper half in shadow mode would never return to 0 at 255. It starts a channel-0 period of 30 and then stages 15 early in that period. The first period must end at 30 and the second at 15. A design that transferred on the write, or never transferred, gives different period lengths. It also writes live words in shadow mode and attempts a mode change while running. Both writes must leave readable state unchanged. It checks wide-mode matches against channels whose high word differs from the counter and channels that are disabled; neither may pulse. It checks the event against the counter value to pin the one-cycle latency.

// File: rtl/shadow_cmp_timer.sv
module shadow_cmp_timer #(
  parameter int NCH = 16,
  parameter int DW  = 32,
  localparam int AW = $clog2(4*NCH),
  localparam int BW = (DW > NCH+2) ? DW : NCH+2
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata,
  output logic [NCH-1:0] evt
);
  localparam int CW = 2*DW;
  localparam int IW = $clog2(NCH);

  logic            run, rst0, shm;
  logic [NCH-1:0]  chen;
  logic [CW-1:0]   cnt;
  logic [DW-1:0]   act_w [NCH];
  logic [DW-1:0]   shd_w [NCH];
  logic [NCH-1:0]  match;

  wire          ch_sel    = addr[AW-1];
  wire [IW-1:0] ch_idx    = addr[AW-2:1];
  wire          wr_ctl    = we && (addr == AW'(0));
  wire          wr_cfg    = we && (addr == AW'(1));
  wire          mode_flip = wr_cfg && !run && (wdata[NCH+1] != shm);
  wire          start     = wr_ctl && wdata[0] && !run;
  wire          rst_hit   = run && rst0 && match[0];
  wire          wrap      = run && shm && (&cnt[DW-1:0]);
  wire          reload    = shm && (start || rst_hit || wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      rst0 <= 1'b0;
      chen <= '0;
      shm  <= 1'b0;
    end else begin
      if (wr_ctl) run <= wdata[0];
      if (wr_cfg) begin
        rst0 <= wdata[0];
        chen <= wdata[NCH:1];
        if (!run) shm <= wdata[NCH+1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (mode_flip)      cnt <= '0;
    else if (run) begin
      if (rst_hit || wrap)   cnt <= '0;
      else                   cnt <= cnt + CW'(1);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire sel = we && ch_sel && (ch_idx == IW'(c));

    assign match[c] = shm ? (cnt[DW-1:0] == act_w[c])
                          : (cnt == {shd_w[c], act_w[c]});

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_w[c] <= '0;
        shd_w[c] <= '0;
      end else begin
        if (reload)                         act_w[c] <= shd_w[c];
        else if (sel && !addr[0] && !shm)   act_w[c] <= wdata[DW-1:0];
        if (sel && addr[0])                 shd_w[c] <= wdata[DW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= '0;
    else        evt <= run ? (match & chen) : '0;
  end

  always_comb begin
    rdata = '0;
    if (ch_sel)
      rdata[DW-1:0] = addr[0] ? shd_w[ch_idx] : act_w[ch_idx];
    else if (addr[AW-2:2] == '0) begin
      case (addr[1:0])
        2'd0: rdata[0]       = run;
        2'd1: rdata[NCH+1:0] = {shm, chen, rst0};
        2'd2: rdata[DW-1:0]  = cnt[DW-1:0];
        default: rdata[DW-1:0] = cnt[CW-1:DW];
      endcase
    end
  end
endmodule

// File: rtl/shadow_cmp_timer_chk.sv
module shadow_cmp_timer_chk #(
  parameter int NCH = 16,
  parameter int DW  = 32,
  localparam int AW = $clog2(4*NCH),
  localparam int BW = (DW > NCH+2) ? DW : NCH+2
)(
  input logic           clk,
  input logic           rst_n,
  input logic           we,
  input logic [AW-1:0]  addr,
  input logic [BW-1:0]  wdata,
  input logic           run,
  input logic           shm,
  input logic [NCH-1:0] chen,
  input logic [2*DW-1:0] cnt,
  input logic [NCH-1:0] evt
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(we && addr == AW'(1))) |=> $stable(cnt));

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shm |-> (cnt[2*DW-1:DW] == '0));

  p_flip_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == AW'(1) && !run && (wdata[NCH+1] != shm)) |=> (cnt == '0));

  p_mode_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && we && addr == AW'(1)) |=> $stable(shm));

  p_evt_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (evt == '0));

  p_evt_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |-> ((evt & ~$past(chen)) == '0));
endmodule

bind shadow_cmp_timer shadow_cmp_timer_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
  .run(run), .shm(shm), .chen(chen), .cnt(cnt), .evt(evt)
);

// File: tb/shadow_cmp_timer_bench.sv
`timescale 1ns/1ps
module shadow_cmp_timer_bench;
  localparam int NCH = 16;
  localparam int DW  = 8;
  localparam logic [17:0] SHD = 18'h20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [17:0] wdata = '0;
  logic [17:0] rdata;
  logic [15:0] evt;
  int nvec = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  shadow_cmp_timer #(.NCH(NCH), .DW(DW)) u_shadow_cmp_timer (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt(evt)
  );

  // {req, we, addr, wdata, expected}
  localparam logic [46:0] VEC [25] = '{
    {4'd1,  1'b0, 6'd0,  18'h0,     18'h0},     // R1
    {4'd1,  1'b0, 6'd1,  18'h0,     18'h0},     // R1
    {4'd1,  1'b0, 6'd2,  18'h0,     18'h0},     // R1
    {4'd1,  1'b0, 6'd38, 18'h0,     18'h0},     // R1
    {4'd4,  1'b1, 6'd38, 18'h5A,    18'h0},
    {4'd4,  1'b0, 6'd38, 18'h0,     18'h5A},    // R4
    {4'd4,  1'b1, 6'd39, 18'h11,    18'h0},
    {4'd4,  1'b0, 6'd39, 18'h0,     18'h11},    // R4
    {4'd10, 1'b1, 6'd2,  18'h77,    18'h0},
    {4'd10, 1'b0, 6'd2,  18'h0,     18'h0},     // R10
    {4'd10, 1'b1, 6'd3,  18'h12,    18'h0},
    {4'd10, 1'b0, 6'd3,  18'h0,     18'h0},     // R10
    {4'd10, 1'b0, 6'd5,  18'h0,     18'h0},     // R10
    {4'd3,  1'b1, 6'd1,  18'h20011, 18'h0},
    {4'd3,  1'b0, 6'd1,  18'h0,     18'h20011}, // R3
    {4'd7,  1'b1, 6'd38, 18'h33,    18'h0},
    {4'd7,  1'b0, 6'd38, 18'h0,     18'h5A},    // R7
    {4'd8,  1'b1, 6'd39, 18'h44,    18'h0},
    {4'd8,  1'b0, 6'd38, 18'h0,     18'h5A},    // R8
    {4'd8,  1'b0, 6'd39, 18'h0,     18'h44},    // R8
    {4'd9,  1'b1, 6'd1,  18'h0,     18'h0},
    {4'd9,  1'b0, 6'd1,  18'h0,     18'h0},     // R9
    {4'd4,  1'b1, 6'd38, 18'h66,    18'h0},
    {4'd4,  1'b0, 6'd38, 18'h0,     18'h66},    // R4
    {4'd9,  1'b0, 6'd2,  18'h0,     18'h0}      // R9 counter cleared
  };

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [17:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [17:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [17:0] d;
    int e5, e6, e7, prev, cur, maxv, drops;
    logic seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 evt idle", {2'b0, evt}, 18'h0);

    for (int i = 0; i < 25; i++) begin
      logic [46:0] v;
      v = VEC[i];
      @(negedge clk);
      we = v[42]; addr = v[41:36]; wdata = v[35:18];
      #1;
      if (!v[42]) chk($sformatf("R%0d vector %0d", v[46:43], i), rdata, v[17:0]);
    end
    @(negedge clk) we = 1'b0;

    // R4 / R11: wide-mode match, high word and enables matter
    wr(6'd42, 18'd20); wr(6'd43, 18'd0);
    wr(6'd44, 18'd20); wr(6'd45, 18'd1);
    wr(6'd46, 18'd20); wr(6'd47, 18'd0);
    wr(6'd1, 18'h000C0);
    wr(6'd0, 18'd1);
    e5 = 0; e6 = 0; e7 = 0;
    @(negedge clk) addr = 6'd2;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      if (evt[5]) begin e5++; chk("R11 counter at ch5 event", rdata, 18'd21); end
      if (evt[6]) e6++;
      if (evt[7]) e7++;
    end
    chk("R4 ch5 pulses", 18'(e5), 18'd1);
    chk("R4 ch6 high word mismatch", 18'(e6), 18'd0);
    chk("R4 ch7 disabled", 18'(e7), 18'd0);
    wr(6'd0, 18'd0);
    rd(6'd2, d); prev = int'(d);
    repeat (5) @(negedge clk);
    rd(6'd2, d);
    chk("R2 stopped counter holds", d, 18'(prev));

    // R5: channel-0 reset in wide mode
    wr(6'd1, SHD); wr(6'd1, 18'd0);
    rd(6'd2, d); chk("R9 mode change clears counter", d, 18'd0);
    wr(6'd32, 18'd9); wr(6'd33, 18'd0);
    wr(6'd1, 18'h3);
    wr(6'd0, 18'd1);
    rd(6'd2, d); prev = int'(d); maxv = prev;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #1;
      cur = int'(rdata);
      chk("R5 R2 counter sequence", rdata, (prev == 9) ? 18'd0 : 18'(prev + 1));
      if (cur > maxv) maxv = cur;
      prev = cur;
    end
    chk("R5 period peak", 18'(maxv), 18'd9);
    wr(6'd0, 18'd0);

    // R6 / R8: shadow mode wrap and transfer
    wr(6'd1, SHD | 18'h8);
    rd(6'd2, d); chk("R9 counter cleared entering shadow", d, 18'd0);
    wr(6'd37, 18'd50);
    wr(6'd0, 18'd1);
    rd(6'd36, d); chk("R8 transfer at start", d, 18'd50);
    wr(6'd37, 18'd60);
    rd(6'd36, d); chk("R8 live word undisturbed", d, 18'd50);
    rd(6'd3, d);  chk("R6 upper word zero", d, 18'd0);
    rd(6'd2, d); prev = int'(d); seen = 1'b0;
    for (int i = 0; i < 600 && !seen; i++) begin
      @(negedge clk); #1;
      cur = int'(rdata);
      if (cur < prev) begin
        seen = 1'b1;
        chk("R6 wrap from all-ones", 18'(prev), 18'd255);
        chk("R6 wrap to zero", 18'(cur), 18'd0);
      end
      prev = cur;
    end
    chk("R6 wrap observed", {17'b0, seen}, 18'd1);
    rd(6'd36, d); chk("R8 transfer at wrap", d, 18'd60);
    wr(6'd1, 18'h8);
    rd(6'd1, d); chk("R9 mode locked while running", d, SHD | 18'h8);
    wr(6'd0, 18'd0);

    // R5 / R7 / R8: shadow mode with channel-0 period
    wr(6'd1, 18'h8);
    wr(6'd1, SHD | 18'h3);
    wr(6'd33, 18'd30);
    wr(6'd0, 18'd1);
    wr(6'd32, 18'd3);
    rd(6'd32, d); chk("R7 live word write ignored", d, 18'd30);
    wr(6'd33, 18'd15);
    rd(6'd2, d); prev = int'(d); drops = 0;
    for (int i = 0; i < 200 && drops < 2; i++) begin
      @(negedge clk); #1;
      cur = int'(rdata);
      if (cur < prev) begin
        drops++;
        chk("R5 reset goes to zero", 18'(cur), 18'd0);
        chk("R8 period set by last transfer", 18'(prev), (drops == 1) ? 18'd30 : 18'd15);
      end
      prev = cur;
    end
    chk("R5 two resets seen", 18'(drops), 18'd2);
    wr(6'd0, 18'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule